// File: doc/BRIEF.md
# GPIO Bank with Level and Edge Event Detection

This block serves a bank of up to 32 general-purpose pins through a word-addressed register interface. Software selects, pin by pin, whether the pad is driven from the output register or left as an input. The sampled pin state can be read back at any time, and the output register can be changed as a whole or through set and clear alias addresses. The set and clear aliases touch only the bits written as 1.

Every input pin is brought into the clock domain by a short synchroniser and then watched by four detectors. These are: low level, high level, rising edge and falling edge. Each detector has its own per-pin enable register, and the enabled detectors of a pin are ORed together. A detected event sets a sticky pending bit, which is cleared by writing 1 to it. The pending bits that are also interrupt-enabled are combined into one interrupt line. A separate wake enable mask picks the pins whose events raise a one-cycle wake request. The wake mask does not depend on the interrupt enables.

Top module: `gpio_event_bank`

## Requirements
- R1: After reset, the following registers read 0: interrupt enable, pending, output, wake enable and all four detector enables. The direction register reads 0xFFFFFFFF, so every pin is an input. The `irq` and `wake_req` outputs are 0.
- R2: `pin_drive_n` always equals the direction register at 0x34. A bit of 1 leaves that pin undriven as an input, and a bit of 0 lets `pin_out` drive the pad.
- R3: The data-in register at 0x38 shows `pin_in` two clock edges after the pin changes. Bus writes to 0x38 have no effect on it.
- R4: `pin_out` follows the output register. A write to 0x3C replaces the register. A write to 0x94 sets, and a write to 0x90 clears, exactly the bits written as 1. The alias addresses read as 0.
- R5: The interrupt enable register is written whole at 0x1C. A write to 0x64 sets, and a write to 0x60 clears, exactly the bits written as 1. Both alias addresses read back the register.
- R6: Low-level detection (0x40) and high-level detection (0x44) set the pending bit on every cycle the level holds. A pending bit that is cleared while the level persists is set again.
- R7: Rising detection (0x48) fires once per 0-to-1 transition of the synchronised pin. Falling detection (0x4C) fires once per 1-to-0 transition. A steady level produces no further edge event.
- R8: All enabled detectors of a pin are ORed. With both edge enables set, a pin raises an event on each transition in either direction.
- R9: The pending register at 0x18 is write-1-to-clear, and writing 0 bits leaves it unchanged. An event arriving in the same cycle as a clear keeps the bit set. Writing 0xFFFFFFFF clears every bit that has no new event.
- R10: `irq` is high exactly when some pending bit has its interrupt enable bit set.
- R11: `wake_req` is high for the cycle after any detected event on a pin whose wake enable bit is set, whatever the interrupt enables are. The wake enable is set at 0x84 and cleared at 0x80, and both addresses read it back.
- R12: Address 0x00 returns the REV_ID parameter and ignores writes. Address 0x14 reads 1 from the first clock after reset. Addresses 0x10 and 0x30 store and return their low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select; also qualifies read data |
| bus_wr | input | 1 | Write strobe, taken when bus_sel is high |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | PINS | Raw pad inputs, asynchronous |
| pin_out | output | PINS | Pad output values |
| pin_drive_n | output | PINS | Per-pin output disable, 1 = input |
| irq | output | 1 | OR of enabled pending bits |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` hold steady across the rising edge and that `pin_in` is either synchronous to the clock or may be seen one cycle later. The bench satisfies this by changing every input on the falling edge. The sticky-pending and single-shot edge properties also assume that detector enables do not change while the related pin toggles. The stimulus therefore programs all enables first and then moves the pins.

// File: rtl/gpio_event_pkg.sv
package gpio_event_pkg;

   localparam int DATA_W    = 32;
   localparam int CFG_W     = 8;
   localparam int CTL_W     = 8;
   localparam int DET_KINDS = 4;

   // Register byte offsets
   localparam logic [7:0] OFS_REV      = 8'h00;
   localparam logic [7:0] OFS_CFG      = 8'h10;
   localparam logic [7:0] OFS_STAT     = 8'h14;
   localparam logic [7:0] OFS_PEND     = 8'h18;
   localparam logic [7:0] OFS_IEN      = 8'h1C;
   localparam logic [7:0] OFS_CTL      = 8'h30;
   localparam logic [7:0] OFS_DIR      = 8'h34;
   localparam logic [7:0] OFS_DIN      = 8'h38;
   localparam logic [7:0] OFS_DOUT     = 8'h3C;
   localparam logic [7:0] OFS_LOW      = 8'h40;
   localparam logic [7:0] OFS_HIGH     = 8'h44;
   localparam logic [7:0] OFS_RISE     = 8'h48;
   localparam logic [7:0] OFS_FALL     = 8'h4C;
   localparam logic [7:0] OFS_IEN_CLR  = 8'h60;
   localparam logic [7:0] OFS_IEN_SET  = 8'h64;
   localparam logic [7:0] OFS_WAKE_CLR = 8'h80;
   localparam logic [7:0] OFS_WAKE_SET = 8'h84;
   localparam logic [7:0] OFS_DOUT_CLR = 8'h90;
   localparam logic [7:0] OFS_DOUT_SET = 8'h94;

   typedef enum logic [1:0] {
      DET_LOW  = 2'd0,
      DET_HIGH = 2'd1,
      DET_RISE = 2'd2,
      DET_FALL = 2'd3
   } det_kind_e;

endpackage

// File: rtl/gpio_event_sync.sv
module gpio_event_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
         end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample,
   input  logic [W-1:0] lo_en,
   input  logic [W-1:0] hi_en,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   output logic [W-1:0] evt
);

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sample;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic lvl_hit;
      logic edge_hit;
      assign lvl_hit  = (lo_en[i] & ~sample[i]) | (hi_en[i] & sample[i]);
      assign edge_hit = (rise_en[i] & sample[i] & ~prev_q[i])
                      | (fall_en[i] & ~sample[i] & prev_q[i]);
      assign evt[i]   = lvl_hit | edge_hit;
   end

   // R7: with no level enable on a pin, its event never lasts two cycles
   a_r7_edge_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt) & evt & ~(lo_en | hi_en) & ~$past(lo_en | hi_en)) == '0));

endmodule

// File: rtl/gpio_event_regs.sv
module gpio_event_regs
   import gpio_event_pkg::*;
#(
   parameter int          PINS   = 32,
   parameter int          ADDR_W = 8,
   parameter logic [31:0] REV_ID = 32'h0000_0021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   din,
   input  logic [PINS-1:0]   evt,
   output logic [PINS-1:0]   dir_n,
   output logic [PINS-1:0]   dout,
   output logic [PINS-1:0]   det_lo,
   output logic [PINS-1:0]   det_hi,
   output logic [PINS-1:0]   det_rise,
   output logic [PINS-1:0]   det_fall,
   output logic              irq,
   output logic              wake_req
);

   localparam logic [ADDR_W-1:0] A_REV      = ADDR_W'(OFS_REV);
   localparam logic [ADDR_W-1:0] A_CFG      = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_PEND     = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_IEN      = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_CTL      = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_DIN      = ADDR_W'(OFS_DIN);
   localparam logic [ADDR_W-1:0] A_DOUT     = ADDR_W'(OFS_DOUT);
   localparam logic [ADDR_W-1:0] A_LOW      = ADDR_W'(OFS_LOW);
   localparam logic [ADDR_W-1:0] A_HIGH     = ADDR_W'(OFS_HIGH);
   localparam logic [ADDR_W-1:0] A_RISE     = ADDR_W'(OFS_RISE);
   localparam logic [ADDR_W-1:0] A_FALL     = ADDR_W'(OFS_FALL);
   localparam logic [ADDR_W-1:0] A_IEN_CLR  = ADDR_W'(OFS_IEN_CLR);
   localparam logic [ADDR_W-1:0] A_IEN_SET  = ADDR_W'(OFS_IEN_SET);
   localparam logic [ADDR_W-1:0] A_WAKE_CLR = ADDR_W'(OFS_WAKE_CLR);
   localparam logic [ADDR_W-1:0] A_WAKE_SET = ADDR_W'(OFS_WAKE_SET);
   localparam logic [ADDR_W-1:0] A_DOUT_CLR = ADDR_W'(OFS_DOUT_CLR);
   localparam logic [ADDR_W-1:0] A_DOUT_SET = ADDR_W'(OFS_DOUT_SET);

   logic                 wr_en;
   logic [PINS-1:0]      wd;
   logic [PINS-1:0]      clr_mask;
   logic [PINS-1:0]      pend_q;
   logic [PINS-1:0]      ien_q;
   logic [PINS-1:0]      wake_en_q;
   logic [PINS-1:0]      dir_q;
   logic [PINS-1:0]      dout_q;
   logic [DET_KINDS-1:0][PINS-1:0] det_q;
   logic [CFG_W-1:0]     cfg_q;
   logic [CTL_W-1:0]     ctl_q;
   logic                 done_q;
   logic                 wake_q;

   assign wr_en    = bus_sel & bus_wr;
   assign wd       = bus_wdata[PINS-1:0];
   assign clr_mask = (wr_en && bus_addr == A_PEND) ? wd : '0;

   // Pending: set by events, cleared by written ones; a new event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_mask) | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         wake_q <= |(evt & wake_en_q);
         done_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q     <= '0;
         wake_en_q <= '0;
         dir_q     <= '1;
         dout_q    <= '0;
         det_q     <= '0;
         cfg_q     <= '0;
         ctl_q     <= '0;
      end else if (wr_en) begin
         case (bus_addr)
            A_CFG:      cfg_q            <= bus_wdata[CFG_W-1:0];
            A_CTL:      ctl_q            <= bus_wdata[CTL_W-1:0];
            A_IEN:      ien_q            <= wd;
            A_IEN_CLR:  ien_q            <= ien_q & ~wd;
            A_IEN_SET:  ien_q            <= ien_q | wd;
            A_WAKE_CLR: wake_en_q        <= wake_en_q & ~wd;
            A_WAKE_SET: wake_en_q        <= wake_en_q | wd;
            A_DIR:      dir_q            <= wd;
            A_DOUT:     dout_q           <= wd;
            A_DOUT_CLR: dout_q           <= dout_q & ~wd;
            A_DOUT_SET: dout_q           <= dout_q | wd;
            A_LOW:      det_q[DET_LOW]   <= wd;
            A_HIGH:     det_q[DET_HIGH]  <= wd;
            A_RISE:     det_q[DET_RISE]  <= wd;
            A_FALL:     det_q[DET_FALL]  <= wd;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         case (bus_addr)
            A_REV:      bus_rdata = REV_ID;
            A_CFG:      bus_rdata = DATA_W'(cfg_q);
            A_STAT:     bus_rdata = DATA_W'(done_q);
            A_PEND:     bus_rdata = DATA_W'(pend_q);
            A_IEN,
            A_IEN_CLR,
            A_IEN_SET:  bus_rdata = DATA_W'(ien_q);
            A_WAKE_CLR,
            A_WAKE_SET: bus_rdata = DATA_W'(wake_en_q);
            A_CTL:      bus_rdata = DATA_W'(ctl_q);
            A_DIR:      bus_rdata = DATA_W'(dir_q);
            A_DIN:      bus_rdata = DATA_W'(din);
            A_DOUT:     bus_rdata = DATA_W'(dout_q);
            A_LOW:      bus_rdata = DATA_W'(det_q[DET_LOW]);
            A_HIGH:     bus_rdata = DATA_W'(det_q[DET_HIGH]);
            A_RISE:     bus_rdata = DATA_W'(det_q[DET_RISE]);
            A_FALL:     bus_rdata = DATA_W'(det_q[DET_FALL]);
            default:    bus_rdata = '0;
         endcase
      end
   end

   assign dir_n    = dir_q;
   assign dout     = dout_q;
   assign det_lo   = det_q[DET_LOW];
   assign det_hi   = det_q[DET_HIGH];
   assign det_rise = det_q[DET_RISE];
   assign det_fall = det_q[DET_FALL];
   assign irq      = |(pend_q & ien_q);
   assign wake_req = wake_q;

   // R9: a pending bit only drops when a 1 was written to it
   a_r9_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(pend_q) & ~$past(clr_mask)) & ~pend_q) == '0));

   // R9: every event is pending on the following cycle, even under a clear
   a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & $past(evt)) == $past(evt)));

   // R11: wake request tracks wake-enabled events one cycle later
   a_r11_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & wake_en_q)) |=> wake_req);

   a_r11_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(evt & wake_en_q)) |=> !wake_req);

endmodule

// File: rtl/gpio_event_bank.sv
module gpio_event_bank
   import gpio_event_pkg::*;
#(
   parameter int          PINS        = 32,
   parameter int          ADDR_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] REV_ID      = 32'h0000_0021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_drive_n,
   output logic              irq,
   output logic              wake_req
);

   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_event_bank: PINS must lie in 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_event_bank: ADDR_W must be at least 8");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_event_bank: SYNC_STAGES must lie in 0..4");
   end

   logic [PINS-1:0] din;
   logic [PINS-1:0] evt;
   logic [PINS-1:0] det_lo;
   logic [PINS-1:0] det_hi;
   logic [PINS-1:0] det_rise;
   logic [PINS-1:0] det_fall;

   gpio_event_sync #(
      .W      (PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (din)
   );

   gpio_event_detect #(
      .W (PINS)
   ) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample  (din),
      .lo_en   (det_lo),
      .hi_en   (det_hi),
      .rise_en (det_rise),
      .fall_en (det_fall),
      .evt     (evt)
   );

   gpio_event_regs #(
      .PINS   (PINS),
      .ADDR_W (ADDR_W),
      .REV_ID (REV_ID)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .din       (din),
      .evt       (evt),
      .dir_n     (pin_drive_n),
      .dout      (pin_out),
      .det_lo    (det_lo),
      .det_hi    (det_hi),
      .det_rise  (det_rise),
      .det_fall  (det_fall),
      .irq       (irq),
      .wake_req  (wake_req)
   );

   // R4: pad outputs change only after a bus write
   a_r4_pins_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out != $past(pin_out)) |-> $past(bus_sel && bus_wr));

   // R10: interrupt rises only after an event or a register write
   a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(|evt) || $past(bus_sel && bus_wr)));

endmodule

// File: tb/tb_gpio_event_bank.sv
module tb_gpio_event_bank;

   localparam logic [31:0] REV = 32'h0000_0021;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_drive_n;
   logic        irq;
   logic        wake_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_event_bank #(.REV_ID(REV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_drive_n(pin_drive_n),
      .irq(irq), .wake_req(wake_req)
   );

   // Behavioural reference model
   logic [31:0] m_s1, m_s2, m_prev, m_pend, m_ien, m_wk, m_dir, m_dout;
   logic [31:0] m_lo, m_hi, m_ri, m_fa;
   logic [7:0]  m_cfg, m_ctl;
   logic        m_done, m_wreq;

   always @(posedge clk) begin
      logic [31:0] ev, clr;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_ien = 0; m_wk = 0;
         m_dir = '1; m_dout = 0; m_lo = 0; m_hi = 0; m_ri = 0; m_fa = 0;
         m_cfg = 0; m_ctl = 0; m_done = 0; m_wreq = 0;
      end else begin
         ev = (m_lo & ~m_s2) | (m_hi & m_s2) | (m_ri & m_s2 & ~m_prev)
            | (m_fa & ~m_s2 & m_prev);
         m_wreq = |(ev & m_wk);
         clr = (bus_sel && bus_wr && bus_addr == 8'h18) ? bus_wdata : 32'h0;
         m_pend = (m_pend & ~clr) | ev;
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               8'h10: m_cfg = bus_wdata[7:0];
               8'h30: m_ctl = bus_wdata[7:0];
               8'h1C: m_ien = bus_wdata;
               8'h60: m_ien = m_ien & ~bus_wdata;
               8'h64: m_ien = m_ien | bus_wdata;
               8'h80: m_wk = m_wk & ~bus_wdata;
               8'h84: m_wk = m_wk | bus_wdata;
               8'h34: m_dir = bus_wdata;
               8'h3C: m_dout = bus_wdata;
               8'h90: m_dout = m_dout & ~bus_wdata;
               8'h94: m_dout = m_dout | bus_wdata;
               8'h40: m_lo = bus_wdata;
               8'h44: m_hi = bus_wdata;
               8'h48: m_ri = bus_wdata;
               8'h4C: m_fa = bus_wdata;
               default: ;
            endcase
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_done = 1'b1;
      end
   end

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h00: return REV;
         8'h10: return {24'h0, m_cfg};
         8'h14: return {31'h0, m_done};
         8'h18: return m_pend;
         8'h1C, 8'h60, 8'h64: return m_ien;
         8'h80, 8'h84: return m_wk;
         8'h30: return {24'h0, m_ctl};
         8'h34: return m_dir;
         8'h38: return m_s2;
         8'h3C: return m_dout;
         8'h40: return m_lo;
         8'h44: return m_hi;
         8'h48: return m_ri;
         8'h4C: return m_fa;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10 irq", {31'h0, irq}, {31'h0, |(m_pend & m_ien)});
         chk("R11 wake_req", {31'h0, wake_req}, {31'h0, m_wreq});
         chk("R4 pin_out", pin_out, m_dout);
         chk("R2 pin_drive_n", pin_drive_n, m_dir);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 chk(tag, bus_rdata, model_read(a));
   endtask

   task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 chk(tag, bus_rdata, exp);
   endtask

   task automatic pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rdx(8'h34, 32'hFFFF_FFFF, "R1 direction");
      rdx(8'h1C, 32'h0, "R1 irq enable");
      rdx(8'h18, 32'h0, "R1 pending");
      rdx(8'h3C, 32'h0, "R1 data out");
      rdx(8'h84, 32'h0, "R1 wake enable");
      rdx(8'h40, 32'h0, "R1 low detect");
      rdx(8'h48, 32'h0, "R1 rise detect");
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 wake", {31'h0, wake_req}, 32'h0);

      // R12 identification and plain registers
      rdx(8'h00, REV, "R12 revision");
      wr(8'h00, 32'hDEAD_BEEF);
      rdx(8'h00, REV, "R12 revision ignores write");
      rdx(8'h14, 32'h1, "R12 sysstatus");
      wr(8'h10, 32'h0000_0155);
      wr(8'h30, 32'h0000_00A3);
      rdx(8'h10, 32'h55, "R12 sysconfig");
      rdx(8'h30, 32'hA3, "R12 control");

      // R2 / R4 direction and output with aliases
      wr(8'h34, 32'hFFFF_0000);
      rdx(8'h34, 32'hFFFF_0000, "R2 direction");
      wr(8'h3C, 32'h0000_A5A5);
      wr(8'h94, 32'h0F00_0001);
      rdx(8'h3C, 32'h0F00_A5A5, "R4 set alias");
      wr(8'h90, 32'h0100_0005);
      rdx(8'h3C, 32'h0E00_A5A0, "R4 clear alias");
      rdx(8'h94, 32'h0, "R4 alias reads zero");
      chk("R4 pin_out", pin_out, 32'h0E00_A5A0);

      // R5 interrupt enable
      wr(8'h1C, 32'h0000_00F0);
      wr(8'h64, 32'h0000_0003);
      wr(8'h60, 32'h0000_0030);
      rdx(8'h1C, 32'h0000_00C3, "R5 enable aliases");
      rd(8'h64, "R5 alias readback");
      wr(8'h1C, 32'h0000_0000);

      // R3 data-in latency and write immunity
      pins(32'h1234_5678);
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h38;
      #1 chk("R3 one edge old", bus_rdata, 32'h0);
      @(negedge clk);
      #1 chk("R3 two edges new", bus_rdata, 32'h1234_5678);
      wr(8'h38, 32'hFFFF_FFFF);
      rdx(8'h38, 32'h1234_5678, "R3 write ignored");
      pins(32'h0);
      idle(4);

      // R6 high-level detection on pin 0, interrupt enabled
      wr(8'h44, 32'h1);
      wr(8'h1C, 32'h1);
      pins(32'h1);
      idle(4);
      rdx(8'h18, 32'h1, "R6 high level pending");
      chk("R10 irq asserted", {31'h0, irq}, 32'h1);
      wr(8'h18, 32'h0);
      rdx(8'h18, 32'h1, "R9 zero write no effect");
      wr(8'h18, 32'h1);
      rdx(8'h18, 32'h1, "R6 reasserts while held");
      pins(32'h0);
      idle(4);
      wr(8'h18, 32'h1);
      rdx(8'h18, 32'h0, "R6 cleared after release");
      wr(8'h44, 32'h0);
      // low-level on pin 2
      wr(8'h40, 32'h4);
      idle(2);
      rdx(8'h18, 32'h4, "R6 low level pending");
      wr(8'h40, 32'h0);
      wr(8'h18, 32'hFFFF_FFFF);
      rdx(8'h18, 32'h0, "R9 clear all");
      chk("R10 irq low", {31'h0, irq}, 32'h0);

      // R7 rising on pin 4 with wake, falling on pin 5, both on pin 6
      wr(8'h48, 32'h0000_0050);
      wr(8'h4C, 32'h0000_0060);
      wr(8'h84, 32'h0000_0010);
      rd(8'h80, "R11 wake readback");
      @(negedge clk); pin_in = 32'h10;
      @(negedge clk);
      @(negedge clk);
      chk("R11 wake not yet", {31'h0, wake_req}, 32'h0);
      @(negedge clk);
      chk("R11 wake pulse", {31'h0, wake_req}, 32'h1);
      chk("R11 independent of irq enable", {31'h0, irq}, 32'h0);
      @(negedge clk);
      chk("R11 wake one cycle", {31'h0, wake_req}, 32'h0);
      rdx(8'h18, 32'h10, "R7 rising pending");
      wr(8'h18, 32'h10);
      idle(3);
      rdx(8'h18, 32'h0, "R7 no event while steady");
      pins(32'h30);
      pins(32'h10);
      idle(4);
      rdx(8'h18, 32'h20, "R7 falling pending");
      wr(8'h18, 32'hFFFF_FFFF);
      pins(32'h50);
      idle(4);
      rdx(8'h18, 32'h40, "R8 both edges rise");
      wr(8'h18, 32'h40);
      pins(32'h10);
      idle(4);
      rdx(8'h18, 32'h40, "R8 both edges fall");
      wr(8'h80, 32'h10);
      rdx(8'h84, 32'h0, "R11 wake cleared");
      wr(8'h64, 32'h40);
      rd(8'h18, "R10 pending model");
      wr(8'h18, 32'hFFFF_FFFF);
      rd(8'h18, "R9 final clear");
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule